// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Cache

This block is a small two-way set-associative read cache. Each set keeps a one-bit pointer that guesses which way the next access to that set will hit. When a request arrives, the guessed way drives the data output and is the only way whose tag is compared in that cycle. A correct guess answers in one cycle. A wrong guess costs one more cycle, in which the other way gets the single tag comparison. When neither way matches, the block fetches the whole line, one word per request, from a simple memory read port. It then installs the line and answers from it.

The CPU side hands over one word address with a valid/ready handshake. Only one request is in flight at a time. Each response is a one-cycle pulse, and it carries two flags: one marks a second-cycle hit and one marks a response served by a refill. A bench or a performance monitor can use these flags to measure how often the prediction is right.

Top module: `wpc_cache`

## Requirements
- R1: After reset every line is invalid and every set's prediction names way 0. In the first cycle after reset, req_ready is 1 and both rsp_valid and mem_req are 0. The first access to any address is a full miss.
- R2: A word address splits, from most significant to least significant, into tag, set index (IDX_W bits) and word offset (OFF_W bits). A refill fetches the words of the missing line in ascending offset order from offset 0. Each memory request carries the address {tag, index, word}.
- R3: A request is taken in a cycle where req_valid and req_ready are both 1. From the next cycle, req_ready stays 0 until the response has been given, so a request held valid during that time is not taken.
- R4: When the predicted way of the set holds a valid matching tag, rsp_valid rises in the cycle after acceptance, with rsp_slow=0 and rsp_refill=0.
- R5: When only the non-predicted way matches, rsp_valid rises two cycles after acceptance with rsp_slow=1 and rsp_refill=0. The set's prediction then names the way that hit.
- R6: On a full miss, mem_req is a one-cycle pulse, and the first one comes three cycles after acceptance. Only one memory request is outstanding at a time, and the next request follows in the cycle after mem_rvalid returns a word. The response comes in the cycle after the last word returns, with rsp_refill=1 and rsp_slow=0.
- R7: The refill victim is way 0 if it is invalid, else way 1 if it is invalid, else the way the set does not predict. After the refill, the set's prediction names the refilled way.
- R8: rsp_data equals the memory word at the requested address, whether the response is a first-cycle hit, a second-cycle hit or a refill.
- R9: req_ready returns to 1 in the cycle after each response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Cache can take a request |
| req_addr | input | ADDR_W | Word address of the request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DATA_W | Response word |
| rsp_slow | output | 1 | Response came from a second-cycle hit |
| rsp_refill | output | 1 | Response came after a line refill |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | ADDR_W | Word address of the memory read |
| mem_rvalid | input | 1 | Memory read data present |
| mem_rdata | input | DATA_W | Memory read data |

## Verification
The coincidence that matters comes when the last memory word of a refill arrives. On that one edge the final data word is written and the line's tag, valid bit and prediction are installed. The response in the following cycle must then read the word that was just written. This is provoked by missing on the last word offset of a line, and it is judged by comparing the response data and the refill flag with a behavioural model in that exact cycle. A second overlap is a request held valid across a busy period. The bench keeps req_valid high between back-to-back requests, and the model checks that the held request is taken only in the cycle after each response.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    localparam int NWAYS = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROBE1,
        S_PROBE2,
        S_FETCH,
        S_WAIT,
        S_DONE
    } wpc_state_e;

    typedef struct packed {
        logic valid;
        logic slow;
        logic refill;
    } wpc_rsp_flags_t;

    function automatic logic alt_way(input logic w);
        return ~w;
    endfunction

    function automatic logic pick_victim(input logic v0, input logic v1, input logic pred);
        if (!v0) return 1'b0;
        if (!v1) return 1'b1;
        return ~pred;
    endfunction

endpackage

// File: rtl/wpc_tag_way.sv
module wpc_tag_way #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/wpc_tags.sv
module wpc_tags
    import wpc_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    input  logic             look_way,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    output logic             look_pred,
    output logic             look_v0,
    output logic             look_v1,
    input  logic             fill_en,
    input  logic             fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             upd_en,
    input  logic             upd_way
);
    localparam int SETS = 1 << IDX_W;

    logic [NWAYS-1:0]            way_vld;
    logic [NWAYS-1:0][TAG_W-1:0] way_tag;
    logic [SETS-1:0]             pred_q;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        wpc_tag_way #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (fill_en && (fill_way == w[0])),
            .wr_idx   (look_idx),
            .wr_tag   (fill_tag),
            .rd_idx   (look_idx),
            .rd_valid (way_vld[w]),
            .rd_tag   (way_tag[w])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
        end else if (fill_en) begin
            pred_q[look_idx] <= fill_way;
        end else if (upd_en) begin
            pred_q[look_idx] <= upd_way;
        end
    end

    // one comparator, steered to a single way per cycle
    assign look_hit  = way_vld[look_way] && (way_tag[look_way] == look_tag);
    assign look_pred = pred_q[look_idx];
    assign look_v0   = way_vld[0];
    assign look_v1   = way_vld[1];
endmodule

// File: rtl/wpc_data.sv
module wpc_data
    import wpc_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_way,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WORDS = 1 << OFF_W;

    logic [DATA_W-1:0] line_q [NWAYS][SETS][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_way][idx][wr_off] <= wr_data;
        end
    end

    assign rd_data = line_q[rd_way][idx][rd_off];
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic [ADDR_W-1:0]                 req_addr,
    output logic                              req_ready,
    input  logic                              cmp_hit,
    input  logic                              set_pred,
    input  logic                              set_v0,
    input  logic                              set_v1,
    output logic                              look_way,
    output logic [IDX_W-1:0]                  look_idx,
    output logic [ADDR_W-IDX_W-OFF_W-1:0]     look_tag,
    output logic [OFF_W-1:0]                  look_off,
    output logic                              fill_en,
    output logic                              fill_way,
    output logic                              upd_en,
    output logic                              dw_en,
    output logic [OFF_W-1:0]                  dw_off,
    output logic                              mem_req,
    output logic [ADDR_W-1:0]                 mem_addr,
    input  logic                              mem_rvalid,
    output wpc_rsp_flags_t                    flags
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_WORD = '1;

    wpc_state_e         st_q, st_d;
    logic [ADDR_W-1:0]  addr_q;
    logic               way_q, way_d;
    logic [OFF_W-1:0]   cnt_q, cnt_d;

    assign look_idx = addr_q[OFF_W +: IDX_W];
    assign look_tag = addr_q[ADDR_W-1 -: TAG_W];
    assign look_off = addr_q[OFF_W-1:0];
    assign req_ready = (st_q == S_IDLE);
    assign fill_way = way_q;
    assign dw_off   = cnt_q;
    assign mem_addr = {look_tag, look_idx, cnt_q};

    always_comb begin
        st_d     = st_q;
        way_d    = way_q;
        cnt_d    = cnt_q;
        look_way = set_pred;
        upd_en   = 1'b0;
        fill_en  = 1'b0;
        dw_en    = 1'b0;
        mem_req  = 1'b0;
        flags    = '0;
        case (st_q)
            S_IDLE: begin
                if (req_valid) st_d = S_PROBE1;
            end
            S_PROBE1: begin
                look_way = set_pred;
                if (cmp_hit) begin
                    flags.valid = 1'b1;
                    st_d        = S_IDLE;
                end else begin
                    st_d = S_PROBE2;
                end
            end
            S_PROBE2: begin
                look_way = alt_way(set_pred);
                if (cmp_hit) begin
                    flags.valid = 1'b1;
                    flags.slow  = 1'b1;
                    upd_en      = 1'b1;
                    st_d        = S_IDLE;
                end else begin
                    way_d = pick_victim(set_v0, set_v1, set_pred);
                    cnt_d = '0;
                    st_d  = S_FETCH;
                end
            end
            S_FETCH: begin
                mem_req = 1'b1;
                st_d    = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rvalid) begin
                    dw_en = 1'b1;
                    if (cnt_q == LAST_WORD) begin
                        fill_en = 1'b1;
                        st_d    = S_DONE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                        st_d  = S_FETCH;
                    end
                end
            end
            S_DONE: begin
                look_way     = way_q;
                flags.valid  = 1'b1;
                flags.refill = 1'b1;
                st_d         = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            addr_q <= '0;
            way_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            st_q  <= st_d;
            way_q <= way_d;
            cnt_q <= cnt_d;
            if (st_q == S_IDLE && req_valid) addr_q <= req_addr;
        end
    end
endmodule

// File: rtl/wpc_cache.sv
module wpc_cache
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_slow,
    output logic              rsp_refill,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic             cmp_hit, set_pred, set_v0, set_v1;
    logic             look_way, fill_en, fill_way, upd_en, dw_en;
    logic [IDX_W-1:0] look_idx;
    logic [TAG_W-1:0] look_tag;
    logic [OFF_W-1:0] look_off, dw_off;
    wpc_rsp_flags_t   flags;

    wpc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_ready  (req_ready),
        .cmp_hit    (cmp_hit),
        .set_pred   (set_pred),
        .set_v0     (set_v0),
        .set_v1     (set_v1),
        .look_way   (look_way),
        .look_idx   (look_idx),
        .look_tag   (look_tag),
        .look_off   (look_off),
        .fill_en    (fill_en),
        .fill_way   (fill_way),
        .upd_en     (upd_en),
        .dw_en      (dw_en),
        .dw_off     (dw_off),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .flags      (flags)
    );

    wpc_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst       (rst),
        .look_idx  (look_idx),
        .look_way  (look_way),
        .look_tag  (look_tag),
        .look_hit  (cmp_hit),
        .look_pred (set_pred),
        .look_v0   (set_v0),
        .look_v1   (set_v1),
        .fill_en   (fill_en),
        .fill_way  (fill_way),
        .fill_tag  (look_tag),
        .upd_en    (upd_en),
        .upd_way   (look_way)
    );

    wpc_data #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (dw_en),
        .wr_way  (fill_way),
        .idx     (look_idx),
        .wr_off  (dw_off),
        .wr_data (mem_rdata),
        .rd_way  (look_way),
        .rd_off  (look_off),
        .rd_data (rsp_data)
    );

    assign rsp_valid  = flags.valid;
    assign rsp_slow   = flags.slow;
    assign rsp_refill = flags.refill;
endmodule

// File: rtl/wpc_cache_chk.sv
module wpc_cache_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic rsp_slow,
    input logic rsp_refill,
    input logic mem_req,
    input logic mem_rvalid
);
    // R3
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    busy_response_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R9
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

    // R6
    single_mem_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R6
    mem_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R6
    refill_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_refill |-> $past(mem_rvalid));

    // R5
    flag_with_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_slow || rsp_refill) |-> rsp_valid);

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_slow && rsp_refill));
endmodule

bind wpc_cache wpc_cache_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_slow   (rsp_slow),
    .rsp_refill (rsp_refill),
    .mem_req    (mem_req),
    .mem_rvalid (mem_rvalid)
);

// File: tb/tb_wpc_cache.sv
module tb_wpc_cache;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 3;
    localparam int OFF_W   = 2;
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int SETS    = 1 << IDX_W;
    localparam int WORDS   = 1 << OFF_W;
    localparam int MEM_LAT = 2;
    localparam int BEAT    = MEM_LAT + 1;
    localparam int MISS_AT = 3 + WORDS * BEAT;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid, rsp_slow, rsp_refill;
    logic [DATA_W-1:0] rsp_data;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;

    always #5 clk = ~clk;

    wpc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_slow(rsp_slow), .rsp_refill(rsp_refill),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [DATA_W-1:0] memfn(input logic [ADDR_W-1:0] a);
        return ({20'h0, a} * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [ADDR_W-1:0] mk(input int t, input int s, input int o);
        logic [TAG_W-1:0] tt = t[TAG_W-1:0];
        logic [IDX_W-1:0] ss = s[IDX_W-1:0];
        logic [OFF_W-1:0] oo = o[OFF_W-1:0];
        return {tt, ss, oo};
    endfunction

    // memory: answers MEM_LAT cycles after a request
    int                mcnt = 0;
    logic [ADDR_W-1:0] maddr = '0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (rst) begin
            mcnt = 0;
        end else begin
            if (mcnt > 0) begin
                mcnt--;
                if (mcnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = memfn(maddr);
                end
            end
            if (mem_req) begin
                mcnt  = MEM_LAT;
                maddr = mem_addr;
            end
        end
    end

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", rq, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit                mv [2][SETS];
    int                mt [2][SETS];
    int                mp [SETS];
    bit                started = 0;
    bit                busy = 0;
    int                e = 0;
    int                resp_at = 0;
    int                kind = 0;
    logic [DATA_W-1:0] exp_data = '0;
    int                base = 0;
    string             kind_rq = "R4";
    string             phase_rq = "";

    task automatic accept(input logic [ADDR_W-1:0] a);
        int s = int'(a[OFF_W +: IDX_W]);
        int t = int'(a[ADDR_W-1 -: TAG_W]);
        int p = mp[s];
        int v;
        if (mv[p][s] && mt[p][s] == t) begin
            kind = 0; resp_at = 1; kind_rq = "R4";
        end else if (mv[1-p][s] && mt[1-p][s] == t) begin
            kind = 1; resp_at = 2; kind_rq = "R5";
            mp[s] = 1 - p;
        end else begin
            kind = 2; resp_at = MISS_AT; kind_rq = "R6";
            // R7 victim: invalid way 0, invalid way 1, else non-predicted
            v = !mv[0][s] ? 0 : (!mv[1][s] ? 1 : 1 - p);
            mv[v][s] = 1; mt[v][s] = t; mp[s] = v;
        end
        if (phase_rq != "") kind_rq = phase_rq;
        exp_data = memfn(a);
        base     = int'(a) & ~(WORDS - 1);
        busy     = 1;
        e        = 1;
    endtask

    always @(negedge clk) begin
        if (!rst && started) begin
            bit exp_rv, exp_mreq;
            chk(busy ? "R3" : "R9", "req_ready", 32'(req_ready), 32'(!busy));
            exp_rv = busy && (e == resp_at);
            chk(kind_rq, "rsp_valid", 32'(rsp_valid), 32'(exp_rv));
            if (exp_rv) begin
                chk(kind == 1 ? "R5" : "R4", "rsp_slow", 32'(rsp_slow), 32'(kind == 1));
                chk("R6", "rsp_refill", 32'(rsp_refill), 32'(kind == 2));
                chk("R8", "rsp_data", rsp_data, exp_data);
            end
            exp_mreq = busy && kind == 2 && e >= 3 && ((e - 3) % BEAT == 0) && ((e - 3) / BEAT < WORDS);
            chk("R6", "mem_req", 32'(mem_req), 32'(exp_mreq));
            if (exp_mreq && mem_req)
                chk("R2", "mem_addr", 32'(mem_addr), 32'(base + (e - 3) / BEAT));
            if (busy) begin
                if (e == resp_at) busy = 0;
                else e++;
            end else if (req_valid) begin
                accept(req_addr);
            end
        end
    end

    task automatic issue(input logic [ADDR_W-1:0] a);
        req_addr  = a;
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic drain();
        req_valid = 1'b0;
        do @(negedge clk); while (busy);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R3 watchdog: actual hung expected response within run limit");
        finish_run();
    end

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        for (int s = 0; s < SETS; s++) begin
            mv[0][s] = 0; mv[1][s] = 0; mt[0][s] = 0; mt[1][s] = 0; mp[s] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: idle state right after reset
        chk("R1", "req_ready", 32'(req_ready), 32'd1);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        started = 1;
        @(posedge clk); #1;

        // R1: empty cache, first access misses; then first-cycle hits (R4)
        phase_rq = "R1";
        issue(mk(1, 0, 2));
        phase_rq = "";
        issue(mk(1, 0, 2));
        issue(mk(1, 0, 3));
        issue(mk(1, 0, 0));

        // R5: conflict in set 1, wrong prediction then corrected
        issue(mk(2, 1, 0));
        issue(mk(3, 1, 1));
        issue(mk(2, 1, 0));
        issue(mk(2, 1, 2));
        issue(mk(3, 1, 3));
        issue(mk(3, 1, 3));
        drain();

        // R7: victim choice under repeated conflict in set 2
        phase_rq = "R7";
        issue(mk(4, 2, 1));
        issue(mk(5, 2, 1));
        issue(mk(6, 2, 1));
        issue(mk(5, 2, 0));
        issue(mk(4, 2, 2));
        issue(mk(6, 2, 3));
        issue(mk(4, 2, 3));
        issue(mk(5, 2, 3));
        phase_rq = "";
        drain();

        // R6: miss on the last word of a line, then a hit on it
        issue(mk(7, 3, 3));
        issue(mk(7, 3, 3));
        idle(3);

        // mixed traffic over a small tag range
        for (int i = 0; i < 250; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            issue(mk(int'(lfsr[1:0]), int'(lfsr[6:4]), int'(lfsr[9:8])));
            if (lfsr[15:13] == 3'b000) idle(2);
        end
        drain();
        idle(4);
        finish_run();
    end
endmodule